// File: doc/BRIEF.md
# Keyboard Matrix Rollover Filter

This block turns snapshots of a 64-key switch matrix into single key events with full N-key rollover. On each scan tick it compares the current snapshot with a record of keys it has already reported. Keys released since the last scan are dropped from that record, and only keys that are down now and absent from the record are kept as "fresh". A key pressed while others are still held is therefore reported, instead of being lost because the full pattern no longer matches one key.

The fresh pattern goes to a sequential lookup over a table of 64-bit patterns held in block RAM. The table is loaded through a write port. The lookup examines one entry per clock. The index of the first exact match becomes the character code, and a pattern that matches nothing yields code 0. A one-cycle strobe marks every result. While a lookup runs, the block reports busy and ignores further scan ticks.

The matrix is seen as eight groups of eight switches. Key number = group × 8 + bit position, so the mask 0x04 of group 6 is bit 50 (the single modifier, shift) and the mask 0x80 of group 6 is bit 55 (space).

Top module: `keymatrix_rollover`

## Requirements
- R1: After reset, `code` is 0, `code_valid` is 0, `busy` is 0 and the reported-key record is empty.
- R2: A scan whose 64 bits are all zero empties the record and produces no strobe. A key pressed after that is reported again.
- R3: A scan that differs from the record only in bit 50 (shift), or not at all, produces no strobe and leaves the record unchanged.
- R4: In any other scan, the fresh pattern is the current bits that are not in the record. A key that becomes pressed while other keys stay held is reported with a pattern that holds only that key.
- R5: Keys absent from the current scan are removed from the record. A key that is released and then pressed again while other keys stay held is reported again. A scan that only releases keys produces no strobe.
- R6: Bit 50 is never kept in the record, but it is part of the fresh pattern. Pressing or releasing shift alone, or around a held key, never produces a strobe. Shift and space pressed from an empty record look up pattern bits 50 and 55, which the test table places at code 9.
- R7: Keys are numbered group × 8 + bit position. The strobe carries the lowest table index whose 64-bit entry equals the fresh pattern exactly.
- R8: When no entry matches, the strobe carries code 0.
- R9: An entry whose upper 16 bits are all ones is an empty slot and never matches, even if it equals the fresh pattern.
- R10: The lookup examines one entry per clock. A match at index k is strobed k+3 rising edges after the edge that accepts the scan. A miss is strobed 130 edges after it. The strobe lasts one cycle.
- R11: `busy` is high from the second edge after an accepted scan until the strobe. A scan tick given while a lookup is pending or running has no effect on the result or on the record.
- R12: `tbl_we` with `tbl_addr` and `tbl_data` writes one table entry on the rising edge. Reset does not alter the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | Sample `key_matrix` as one scan |
| key_matrix | input | 64 | Current switch states, key = group*8 + bit |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 7 | Table entry index to write |
| tbl_data | input | 64 | Pattern written to the table |
| busy | output | 1 | Lookup in progress; scans are ignored |
| code | output | 7 | Character code of the last event |
| code_valid | output | 1 | One-cycle strobe for `code` |

## Verification
A stale or over-full reported-key record shows up at the ports on the next scan. A wrongly kept key produces a missing strobe when that key is pressed again. A wrongly dropped key produces an extra strobe on a scan that should be silent. A shift bit left in the record makes shift-plus-space produce no event. A lookup that is off by one in its index, its read latency or its stop condition shows up as a wrong code or a wrong strobe cycle within one table sweep, so the bench checks the exact cycle of every strobe.

// File: rtl/kbd_rollover_pkg.sv
package kbd_rollover_pkg;
  // Decision taken on an accepted scan
  typedef enum logic [1:0] {
    SCAN_IGNORE = 2'd0,
    SCAN_CLEAR  = 2'd1,
    SCAN_HOLD   = 2'd2,
    SCAN_UPDATE = 2'd3
  } scan_act_e;
endpackage

// File: rtl/kbd_code_mem.sv
module kbd_code_mem #(
  parameter int ENTRIES = 128,
  parameter int WIDTH   = 64,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_en,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [ENTRIES];

  // simple dual port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (rd_en) rdata <= mem[raddr];
  end
endmodule

// File: rtl/kbd_debounce.sv
module kbd_debounce
  import kbd_rollover_pkg::*;
#(
  parameter int GROUPS    = 8,
  parameter int GROUP_W   = 8,
  parameter int SHIFT_IDX = 50,
  localparam int KEYS     = GROUPS * GROUP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_tick,
  input  logic            lookup_busy,
  input  logic [KEYS-1:0] matrix,
  output logic            start,
  output logic [KEYS-1:0] pattern
);
  localparam logic [KEYS-1:0] NO_SHIFT = ~(KEYS'(1) << SHIFT_IDX);

  logic [KEYS-1:0]   seen;
  logic [GROUPS-1:0] grp_any;
  logic              any_down, accept;
  logic [KEYS-1:0]   diff, kept, fresh;
  scan_act_e         act;

  // per-group activity, then a reduction over groups
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_any[g] = |matrix[g*GROUP_W +: GROUP_W];
  end
  assign any_down = |grp_any;

  assign accept = scan_tick && !lookup_busy && !start;
  assign diff   = (matrix ^ seen) & NO_SHIFT;
  assign kept   = seen & matrix;
  assign fresh  = matrix & ~kept;

  always_comb begin
    if (!accept)           act = SCAN_IGNORE;
    else if (!any_down)    act = SCAN_CLEAR;
    else if (diff == '0)   act = SCAN_HOLD;
    else                   act = SCAN_UPDATE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= '0;
      start   <= 1'b0;
      pattern <= '0;
    end else begin
      start <= 1'b0;
      case (act)
        SCAN_CLEAR:  seen <= '0;
        SCAN_UPDATE: begin
          seen <= (kept | fresh) & NO_SHIFT;
          if ((fresh & NO_SHIFT) != '0) begin
            start   <= 1'b1;
            pattern <= fresh;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: an all-released scan empties the record
  assert_clear_on_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && !any_down) |=> (seen == '0));
  // R5: released keys never survive an update
  assert_drop_released_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && any_down && diff != '0) |=> ((seen & ~$past(matrix)) == '0));
  // R3: a hold scan leaves the record alone
  assert_hold_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && any_down && diff == '0) |=> $stable(seen));
  // R11: a new lookup is only requested while the sequencer is idle
  assert_start_idle_R11: assert property (@(posedge clk) disable iff (rst)
    start |-> !lookup_busy);
endmodule

// File: rtl/kbd_lookup_seq.sv
module kbd_lookup_seq #(
  parameter int ENTRIES = 128,
  parameter int KEYS    = 64,
  parameter int CODE_W  = 7,
  parameter int EMPTY_W = 16,
  localparam int AW     = $clog2(ENTRIES),
  localparam int IW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [KEYS-1:0]   pattern,
  input  logic [KEYS-1:0]   rd_data,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic              busy,
  output logic [CODE_W-1:0] code,
  output logic              code_valid
);
  logic [KEYS-1:0] pat;
  logic [IW-1:0]   idx;
  logic [AW-1:0]   rd_idx;
  logic            rd_vld;
  logic            slot_empty, hit, last;

  assign rd_en   = busy && (idx < IW'(ENTRIES));
  assign rd_addr = idx[AW-1:0];

  assign slot_empty = &rd_data[KEYS-1 -: EMPTY_W];
  assign hit        = rd_vld && !slot_empty && (rd_data == pat);
  assign last       = rd_vld && (rd_idx == AW'(ENTRIES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pat        <= '0;
      idx        <= '0;
      rd_idx     <= '0;
      rd_vld     <= 1'b0;
      busy       <= 1'b0;
      code       <= '0;
      code_valid <= 1'b0;
    end else begin
      code_valid <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        idx    <= '0;
        pat    <= pattern;
        rd_vld <= 1'b0;
      end else if (busy) begin
        rd_vld <= rd_en;
        rd_idx <= rd_addr;
        if (rd_en) idx <= idx + 1'b1;
        if (hit) begin
          code       <= CODE_W'(rd_idx);
          code_valid <= 1'b1;
          busy       <= 1'b0;
          rd_vld     <= 1'b0;
        end else if (last) begin
          code       <= '0;
          code_valid <= 1'b1;
          busy       <= 1'b0;
          rd_vld     <= 1'b0;
        end
      end
    end
  end

  // R10: the strobe is a single cycle
  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
    code_valid |=> !code_valid);
  // R11: every strobe ends a lookup
  assert_strobe_ends_busy_R11: assert property (@(posedge clk) disable iff (rst)
    code_valid |-> (!busy && $past(busy)));
  // R10: the index never runs past the table
  assert_idx_bound_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx <= IW'(ENTRIES)));
  // R9: an empty slot is never reported as a hit
  assert_empty_never_hits_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && slot_empty && busy) |=> !(code_valid && code == CODE_W'($past(rd_idx)) && $past(rd_idx) != '0));
endmodule

// File: rtl/keymatrix_rollover.sv
module keymatrix_rollover #(
  parameter int GROUPS      = 8,
  parameter int GROUP_W     = 8,
  parameter int SHIFT_GROUP = 6,
  parameter int SHIFT_POS   = 2,
  parameter int ENTRIES     = 128,
  parameter int CODE_W      = 7,
  parameter int EMPTY_W     = 16,
  localparam int KEYS       = GROUPS * GROUP_W,
  localparam int AW         = $clog2(ENTRIES),
  localparam int SHIFT_IDX  = SHIFT_GROUP * GROUP_W + SHIFT_POS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_tick,
  input  logic [KEYS-1:0]   key_matrix,
  input  logic              tbl_we,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [KEYS-1:0]   tbl_data,
  output logic              busy,
  output logic [CODE_W-1:0] code,
  output logic              code_valid
);
  logic            start;
  logic [KEYS-1:0] pattern;
  logic            rd_en;
  logic [AW-1:0]   rd_addr;
  logic [KEYS-1:0] rd_data;

  kbd_debounce #(
    .GROUPS    (GROUPS),
    .GROUP_W   (GROUP_W),
    .SHIFT_IDX (SHIFT_IDX)
  ) u_deb (
    .clk         (clk),
    .rst         (rst),
    .scan_tick   (scan_tick),
    .lookup_busy (busy),
    .matrix      (key_matrix),
    .start       (start),
    .pattern     (pattern)
  );

  kbd_code_mem #(
    .ENTRIES (ENTRIES),
    .WIDTH   (KEYS)
  ) u_mem (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .rd_en (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  kbd_lookup_seq #(
    .ENTRIES (ENTRIES),
    .KEYS    (KEYS),
    .CODE_W  (CODE_W),
    .EMPTY_W (EMPTY_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pattern    (pattern),
    .rd_data    (rd_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .busy       (busy),
    .code       (code),
    .code_valid (code_valid)
  );

  // R7: a lookup only begins from a pattern holding some non-shift key
  assert_start_has_key_R7: assert property (@(posedge clk) disable iff (rst)
    start |-> ((pattern & ~(KEYS'(1) << SHIFT_IDX)) != '0));
endmodule

// File: tb/tb_keymatrix_rollover.sv
`timescale 1ns/1ps
module tb_keymatrix_rollover;
  localparam logic [63:0] SH = 64'd1 << 50;
  localparam logic [63:0] SP = 64'd1 << 55;
  localparam logic [63:0] NOSH = ~SH;
  localparam logic [63:0] EMPTY_PAT = {16'hFFFF, 48'h0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_tick = 1'b0;
  logic [63:0] key_matrix = '0;
  logic        tbl_we = 1'b0;
  logic [6:0]  tbl_addr = '0;
  logic [63:0] tbl_data = '0;
  logic        busy;
  logic [6:0]  code;
  logic        code_valid;

  int errors = 0;
  int checks = 0;
  logic [63:0] mdeb = '0;

  always #10 clk = ~clk;

  keymatrix_rollover dut (
    .clk(clk), .rst(rst), .scan_tick(scan_tick), .key_matrix(key_matrix),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .busy(busy), .code(code), .code_valid(code_valid)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // R12 test table contents
  function automatic logic [63:0] tbl_entry(input int i);
    if (i == 9) return SH | SP;
    if (i >= 10 && i <= 73) return 64'd1 << (i - 10);
    if (i == 100) return 64'h18;
    if (i == 5) return EMPTY_PAT;
    return '1;
  endfunction

  // R7/R8/R9: expected lookup result; returns index, -1 for a miss
  function automatic int exp_index(input logic [63:0] p);
    if (p == (SH | SP)) return 9;
    if (p == 64'h18) return 100;
    if ($countones(p) == 1)
      for (int b = 0; b < 64; b++) if (p[b]) return 10 + b;
    return -1;
  endfunction

  // scan with optional extra tick while the lookup is pending (R11)
  task automatic scan(input logic [63:0] m, input bit inject,
                      input logic [63:0] inj_m, input string tag);
    logic [63:0] fresh;
    bit ev;
    int idx, exp_code, exp_lat, pulses, got_code, got_lat;
    ev = 1'b0;
    fresh = '0;
    if (m == '0) mdeb = '0;
    else if (((m ^ mdeb) & NOSH) != '0) begin
      fresh = m & ~mdeb;
      mdeb  = m & NOSH;
      ev    = (fresh & NOSH) != '0;
    end
    idx = exp_index(fresh);
    exp_code = (idx < 0) ? 0 : idx;
    exp_lat  = (idx < 0) ? 131 : idx + 4;
    pulses = 0; got_code = 0; got_lat = 0;
    key_matrix = m;
    scan_tick = 1'b1;
    @(negedge clk);
    scan_tick = 1'b0;
    for (int n = 1; n <= 140; n++) begin
      if (inject && n == 5) begin key_matrix = inj_m; scan_tick = 1'b1; end
      if (inject && n == 6) scan_tick = 1'b0;
      if (n == 2) chk(busy == ev, {tag, " R11 busy"}, busy, ev);
      if (code_valid) begin
        pulses++;
        got_code = code;
        got_lat = n;
      end
      @(negedge clk);
    end
    chk(pulses == int'(ev), {tag, " R4 event count"}, pulses, ev);
    if (ev) begin
      chk(got_code == exp_code, {tag, " R7 code"}, got_code, exp_code);
      chk(got_lat == exp_lat, {tag, " R10 latency"}, got_lat, exp_lat);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(code == 0, "R1 code", code, 0);
    chk(code_valid == 0, "R1 strobe", code_valid, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    // R12 load table
    for (int i = 0; i < 128; i++) begin
      tbl_we = 1'b1; tbl_addr = 7'(i); tbl_data = tbl_entry(i);
      @(negedge clk);
    end
    tbl_we = 1'b0;
    // R7/R10 single keys across every group and bit, R2 release between
    for (int b = 0; b < 64; b++) begin
      if (b == 50) continue;
      scan(64'd1 << b, 0, '0, "R7 single");
      scan('0, 0, '0, "R2 release");
    end
    // R4 rollover and R5 re-press
    scan(64'd1 << 1, 0, '0, "R4 first");
    scan((64'd1 << 1) | (64'd1 << 2), 0, '0, "R4 rollover");
    scan(64'd1 << 2, 0, '0, "R5 release only");
    scan((64'd1 << 1) | (64'd1 << 2), 0, '0, "R5 repress");
    scan((64'd1 << 1) | (64'd1 << 2), 0, '0, "R3 unchanged");
    scan('0, 0, '0, "R2 clear");
    // R6 shift handling
    scan(SP, 0, '0, "R6 space");
    scan(SP | SH, 0, '0, "R6 add shift");
    scan(SP, 0, '0, "R6 drop shift");
    scan('0, 0, '0, "R2 clear");
    scan(SH, 0, '0, "R6 shift alone");
    scan(SH | SP, 0, '0, "R6 shift space");
    scan(SP, 0, '0, "R6 release shift");
    scan('0, 0, '0, "R2 clear");
    // R7 two-key entry, R8 miss, R9 empty slot
    scan(64'h18, 0, '0, "R7 pair");
    scan('0, 0, '0, "R2 clear");
    scan(64'h60, 0, '0, "R8 miss");
    scan('0, 0, '0, "R2 clear");
    scan(EMPTY_PAT, 0, '0, "R9 empty slot");
    scan('0, 0, '0, "R2 clear");
    // R11 tick during lookup ignored
    scan(64'd1 << 3, 1, 64'd1 << 20, "R11 ignored tick");
    scan(64'd1 << 20, 0, '0, "R11 after ignore");
    scan('0, 0, '0, "R2 clear");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule